// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block hands the direction of a bidirectional serial data lane from one end to the other using low-power signalling only. Each end carries one copy. The end that owns the lane gives it up through a fixed sequence of line states and then stops driving. The end that is listening waits for a Mark-1 level from the far side and then takes over. All intervals are whole multiples of a programmable low-power unit counted in core clock cycles. The block also covers entry into and exit from the ultra-low-power state. Exit drives Mark-1 for a long interval that a separate, wider counter measures.

The sampled low-power pair comes in on `line_in`, and the pair to drive goes out on `line_out` with an output enable. `dir_tx` shows which end currently owns the lane. Bit 1 of every line code is the positive wire and bit 0 is the negative wire: stop is 2'b11, Mark-1 is 2'b10 and the bridge level is 2'b00. The length of the unit, the takeover wait and the wake-up time are held on inputs. They are read while a sequence runs, so software must keep them steady during a turnaround or wake-up.

Top module: `dphy_ta_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, the block owns the lane (`dir_tx`=1, `drive_en`=1) and drives stop (2'b11).
- R2: A `ta_req` seen while idle as owner starts a release that drives stop, Mark-1 (2'b10), bridge (2'b00) and Mark-1, each for exactly one unit.
- R3: The release ends with the bridge level (2'b00) held for exactly four units. After that `drive_en` and `dir_tx` both go to 0 and `line_out` rests at 2'b11.
- R4: A listening block that samples Mark-1 (2'b10) on `line_in` waits without driving for `sure_cycles` clock cycles, clamped to the range from one unit to two units.
- R5: After that wait the block drives the bridge level (2'b00) with `dir_tx`=0 for exactly five units.
- R6: It then drives Mark-1 (2'b10) for one unit, and after that drives stop (2'b11) with `dir_tx`=1.
- R7: The unit is `lpx_cycles` clock cycles, raised to the parameter `MIN_LPX` when the input is smaller.
- R8: `ulps_req` seen while idle as owner makes the block drive the bridge level (2'b00) for as long as it stays high. It wins over a `ta_req` that arrives in the same cycle.
- R9: When `ulps_req` falls in the ultra-low-power state, the block drives Mark-1 (2'b10) for max(`wake_cycles`, `MIN_WAKE`) cycles and then drives stop (2'b11).
- R10: `ta_req`, `ulps_req` and `line_in` have no effect on the timing or the levels of a release or a takeover once it has started.
- R11: While listening, `ta_req` and `ulps_req` are ignored and the block does not drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lpx_cycles | input | LPX_W | Length of one low-power unit in clock cycles |
| sure_cycles | input | LPX_W+1 | Takeover wait after Mark-1 is seen, in cycles |
| wake_cycles | input | WAKE_W | Mark-1 time when leaving the ultra-low-power state |
| ta_req | input | 1 | Request to hand the lane to the far end |
| ulps_req | input | 1 | Hold the ultra-low-power state while high |
| line_in | input | 2 | Sampled low-power pair {positive, negative} |
| line_out | output | 2 | Low-power pair to drive {positive, negative} |
| drive_en | output | 1 | Output enable for the low-power drivers |
| dir_tx | output | 1 | 1 while this end owns the lane |

## Verification
A table of unit and wait settings runs full release-and-takeover cycles. It covers a wait inside the allowed window, a wait below one unit, a wait above two units, a wait exactly on each bound, and a unit below the minimum. Comparing the measured run lengths of each line state shows whether the block clamps the unit, clamps the wait, or counts either one off by a cycle. A second pass holds `ta_req`, `ulps_req` and a false Mark-1 on `line_in` during a sequence and compares the timing with a clean pass, so any leak of those inputs into the sequence shows up. Directed tests cover the reset state, listening under requests, the priority of the ultra-low-power request over a turnaround request, and a wake-up time both above and below its minimum.

// File: rtl/dphy_ta_pkg.sv
package dphy_ta_pkg;

   typedef enum logic [3:0] {
      S_TX_STOP   = 4'd0,
      S_REL_STOP  = 4'd1,
      S_REL_M1A   = 4'd2,
      S_REL_BRA   = 4'd3,
      S_REL_M1B   = 4'd4,
      S_REL_GO    = 4'd5,
      S_RX_LISTEN = 4'd6,
      S_RX_SURE   = 4'd7,
      S_RX_GET    = 4'd8,
      S_RX_M1     = 4'd9,
      S_ULPS      = 4'd10,
      S_WAKE      = 4'd11
   } ta_state_t;

   // low-power pair codes, {positive wire, negative wire}
   localparam logic [1:0] LINE_STOP   = 2'b11;
   localparam logic [1:0] LINE_MARK1  = 2'b10;
   localparam logic [1:0] LINE_BRIDGE = 2'b00;

endpackage

// File: rtl/dphy_ta_cycle_timer.sv
module dphy_ta_cycle_timer #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic [W-1:0] dur,
   output logic         done
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_q <= '0;
      else if (clear) count_q <= '0;
      else            count_q <= count_q + ONE;
   end

   assign done = (count_q == (dur - ONE));

   // the owner of this timer restarts it on every terminal count
   AST_CLEAR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (count_q == '0)); // R2

endmodule

// File: rtl/dphy_ta_limits.sv
module dphy_ta_limits #(
   parameter int LPX_W    = 8,
   parameter int MIN_LPX  = 10,
   parameter int WAKE_W   = 20,
   parameter int MIN_WAKE = 200000,
   parameter int SEG_W    = LPX_W + 3
) (
   input  logic [LPX_W-1:0]  lpx_cycles,
   input  logic [LPX_W:0]    sure_cycles,
   input  logic [WAKE_W-1:0] wake_cycles,
   output logic [SEG_W-1:0]  lpx_dur,
   output logic [SEG_W-1:0]  go_dur,
   output logic [SEG_W-1:0]  get_dur,
   output logic [SEG_W-1:0]  sure_dur,
   output logic [WAKE_W-1:0] wake_dur
);

   localparam logic [LPX_W-1:0]  MIN_LPX_V  = LPX_W'(MIN_LPX);
   localparam logic [WAKE_W-1:0] MIN_WAKE_V = WAKE_W'(MIN_WAKE);

   logic [LPX_W-1:0] unit;
   logic [LPX_W:0]   unit_x1;
   logic [LPX_W:0]   unit_x2;
   logic [LPX_W:0]   sure_eff;

   generate
      if (MIN_LPX <= 1) begin : g_unit_raw
         assign unit = lpx_cycles;
      end else begin : g_unit_clamp
         assign unit = (lpx_cycles < MIN_LPX_V) ? MIN_LPX_V : lpx_cycles;
      end
   endgenerate

   assign unit_x1 = {1'b0, unit};
   assign unit_x2 = {unit, 1'b0};

   always_comb begin
      if (sure_cycles < unit_x1)      sure_eff = unit_x1;
      else if (sure_cycles > unit_x2) sure_eff = unit_x2;
      else                            sure_eff = sure_cycles;
   end

   assign lpx_dur  = {3'b000, unit};
   assign go_dur   = {1'b0, unit, 2'b00};
   assign get_dur  = go_dur + lpx_dur;
   assign sure_dur = {2'b00, sure_eff};
   assign wake_dur = (wake_cycles < MIN_WAKE_V) ? MIN_WAKE_V : wake_cycles;

endmodule

// File: rtl/dphy_ta_fsm.sv
module dphy_ta_fsm
   import dphy_ta_pkg::*;
#(
   parameter int SEG_W       = 11,
   parameter bit RESET_OWNER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ta_req,
   input  logic             ulps_req,
   input  logic [1:0]       line_in,
   input  logic [SEG_W-1:0] lpx_dur,
   input  logic [SEG_W-1:0] go_dur,
   input  logic [SEG_W-1:0] get_dur,
   input  logic [SEG_W-1:0] sure_dur,
   input  logic             seg_done,
   input  logic             wake_done,
   output logic             seg_clear,
   output logic [SEG_W-1:0] seg_dur,
   output logic             wake_clear,
   output logic [1:0]       line_out,
   output logic             drive_en,
   output logic             dir_tx
);

   ta_state_t state_q, state_d, rst_state;
   logic      timed;

   generate
      if (RESET_OWNER) begin : g_rst_owner
         assign rst_state = S_TX_STOP;
      end else begin : g_rst_listen
         assign rst_state = S_RX_LISTEN;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= rst_state;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_TX_STOP: begin
            if (ulps_req)    state_d = S_ULPS;
            else if (ta_req) state_d = S_REL_STOP;
         end
         S_REL_STOP:  if (seg_done) state_d = S_REL_M1A;
         S_REL_M1A:   if (seg_done) state_d = S_REL_BRA;
         S_REL_BRA:   if (seg_done) state_d = S_REL_M1B;
         S_REL_M1B:   if (seg_done) state_d = S_REL_GO;
         S_REL_GO:    if (seg_done) state_d = S_RX_LISTEN;
         S_RX_LISTEN: if (line_in == LINE_MARK1) state_d = S_RX_SURE;
         S_RX_SURE:   if (seg_done) state_d = S_RX_GET;
         S_RX_GET:    if (seg_done) state_d = S_RX_M1;
         S_RX_M1:     if (seg_done) state_d = S_TX_STOP;
         S_ULPS:      if (!ulps_req) state_d = S_WAKE;
         S_WAKE:      if (wake_done) state_d = S_TX_STOP;
         default:     state_d = rst_state;
      endcase
   end

   always_comb begin
      case (state_q)
         S_REL_STOP, S_REL_M1A, S_REL_BRA, S_REL_M1B, S_REL_GO,
         S_RX_SURE, S_RX_GET, S_RX_M1: timed = 1'b1;
         default:                      timed = 1'b0;
      endcase
   end

   always_comb begin
      case (state_q)
         S_REL_GO:  seg_dur = go_dur;
         S_RX_SURE: seg_dur = sure_dur;
         S_RX_GET:  seg_dur = get_dur;
         default:   seg_dur = lpx_dur;
      endcase
   end

   assign seg_clear  = !timed || (state_d != state_q);
   assign wake_clear = (state_q != S_WAKE) || (state_d != state_q);

   always_comb begin
      line_out = LINE_STOP;
      drive_en = 1'b1;
      dir_tx   = 1'b1;
      case (state_q)
         S_REL_M1A, S_REL_M1B, S_WAKE: line_out = LINE_MARK1;
         S_REL_BRA, S_REL_GO, S_ULPS:  line_out = LINE_BRIDGE;
         S_RX_LISTEN, S_RX_SURE: begin
            drive_en = 1'b0;
            dir_tx   = 1'b0;
         end
         S_RX_GET: begin
            line_out = LINE_BRIDGE;
            dir_tx   = 1'b0;
         end
         S_RX_M1: begin
            line_out = LINE_MARK1;
            dir_tx   = 1'b0;
         end
         default: ;
      endcase
   end

   AST_RELEASE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dir_tx) |-> !drive_en); // R3

   AST_TAKEOVER_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_tx && drive_en) |-> (line_out != LINE_STOP)); // R5

   AST_OWNER_FROM_MARK1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dir_tx) |-> ($past(line_out) == LINE_MARK1 && line_out == LINE_STOP)); // R6

   AST_ULPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_TX_STOP && ulps_req) |=> (line_out == LINE_BRIDGE && drive_en)); // R8

   AST_WAKE_MARK1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_ULPS && !ulps_req) |=> (line_out == LINE_MARK1 && drive_en)); // R9

   AST_LISTEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RX_LISTEN && line_in != LINE_MARK1) |=> !drive_en); // R11

endmodule

// File: rtl/dphy_ta_ctrl.sv
module dphy_ta_ctrl #(
   parameter int LPX_W       = 8,
   parameter int MIN_LPX     = 10,
   parameter int WAKE_W      = 20,
   parameter int MIN_WAKE    = 200000,
   parameter bit RESET_OWNER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LPX_W-1:0]  lpx_cycles,
   input  logic [LPX_W:0]    sure_cycles,
   input  logic [WAKE_W-1:0] wake_cycles,
   input  logic              ta_req,
   input  logic              ulps_req,
   input  logic [1:0]        line_in,
   output logic [1:0]        line_out,
   output logic              drive_en,
   output logic              dir_tx
);

   localparam int SEG_W = LPX_W + 3;

   initial begin
      AST_PARAM_LPX: assert (MIN_LPX >= 1 && MIN_LPX < (1 << LPX_W))
         else $error("MIN_LPX out of range"); // R7
      AST_PARAM_WAKE: assert (MIN_WAKE >= 1 && MIN_WAKE < (1 << WAKE_W))
         else $error("MIN_WAKE out of range"); // R9
   end

   logic [SEG_W-1:0]  lpx_dur, go_dur, get_dur, sure_dur, seg_dur;
   logic [WAKE_W-1:0] wake_dur;
   logic              seg_clear, seg_done, wake_clear, wake_done;

   dphy_ta_limits #(
      .LPX_W(LPX_W), .MIN_LPX(MIN_LPX), .WAKE_W(WAKE_W),
      .MIN_WAKE(MIN_WAKE), .SEG_W(SEG_W)
   ) limits_i (
      .lpx_cycles(lpx_cycles), .sure_cycles(sure_cycles),
      .wake_cycles(wake_cycles), .lpx_dur(lpx_dur), .go_dur(go_dur),
      .get_dur(get_dur), .sure_dur(sure_dur), .wake_dur(wake_dur)
   );

   dphy_ta_cycle_timer #(.W(SEG_W)) seg_timer_i (
      .clk(clk), .rst_n(rst_n), .clear(seg_clear), .dur(seg_dur),
      .done(seg_done)
   );

   dphy_ta_cycle_timer #(.W(WAKE_W)) wake_timer_i (
      .clk(clk), .rst_n(rst_n), .clear(wake_clear), .dur(wake_dur),
      .done(wake_done)
   );

   dphy_ta_fsm #(.SEG_W(SEG_W), .RESET_OWNER(RESET_OWNER)) fsm_i (
      .clk(clk), .rst_n(rst_n), .ta_req(ta_req), .ulps_req(ulps_req),
      .line_in(line_in), .lpx_dur(lpx_dur), .go_dur(go_dur),
      .get_dur(get_dur), .sure_dur(sure_dur), .seg_done(seg_done),
      .wake_done(wake_done), .seg_clear(seg_clear), .seg_dur(seg_dur),
      .wake_clear(wake_clear), .line_out(line_out), .drive_en(drive_en),
      .dir_tx(dir_tx)
   );

endmodule

// File: tb/dphy_ta_ctrl_tb.sv
`timescale 1ns/1ps
module dphy_ta_ctrl_tb_top;

   localparam int LPX_W    = 8;
   localparam int WAKE_W   = 20;
   localparam int MIN_LPX  = 4;
   localparam int MIN_WAKE = 30;
   localparam int NVEC     = 6;

   // {lpx_cycles, sure_cycles, expected unit, expected wait}
   localparam int VEC [NVEC][4] = '{
      '{6, 9, 6, 9},
      '{5, 2, 5, 5},
      '{4, 20, 4, 8},
      '{2, 3, 4, 4},
      '{10, 20, 10, 20},
      '{7, 7, 7, 7}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LPX_W-1:0]  lpx_cycles = 8'd6;
   logic [LPX_W:0]    sure_cycles = 9'd6;
   logic [WAKE_W-1:0] wake_cycles = '0;
   logic              ta_req = 1'b0;
   logic              ulps_req = 1'b0;
   logic [1:0]        line_in = 2'b11;
   logic [1:0]        line_out;
   logic              drive_en, dir_tx;
   logic [3:0]        obs;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   dphy_ta_ctrl #(
      .LPX_W(LPX_W), .MIN_LPX(MIN_LPX), .WAKE_W(WAKE_W), .MIN_WAKE(MIN_WAKE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .lpx_cycles(lpx_cycles),
      .sure_cycles(sure_cycles), .wake_cycles(wake_cycles), .ta_req(ta_req),
      .ulps_req(ulps_req), .line_in(line_in), .line_out(line_out),
      .drive_en(drive_en), .dir_tx(dir_tx)
   );

   // observed key: {dir_tx, drive_en, line_out}
   assign obs = {dir_tx, drive_en, line_out};

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_len(input logic [3:0] k, output int n);
      n = 0;
      while (obs == k && n < 4000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic release_part(input int u, input bit noisy);
      int n;
      ta_req = 1'b1;
      if (noisy) line_in = 2'b10;
      @(negedge clk);
      if (!noisy) ta_req = 1'b0;
      run_len(4'b1111, n); chk("R2 stop unit", n, u);
      run_len(4'b1110, n); chk("R2 first mark1", n, u);
      run_len(4'b1100, n); chk("R2 first bridge", n, u);
      run_len(4'b1110, n); chk("R2 second mark1", n, u);
      if (noisy) begin
         ta_req  = 1'b0;
         line_in = 2'b11;
      end
      run_len(4'b1100, n); chk(noisy ? "R10 go bridge" : "R3 go bridge", n, 4 * u);
      chk("R3 released", int'(obs), 4'b0011);
   endtask

   task automatic take_part(input int u, input int w, input bit noisy);
      int n;
      line_in = 2'b10;
      @(negedge clk);
      line_in = 2'b11;
      run_len(4'b0011, n); chk("R4 wait", n, w);
      if (noisy) begin
         ta_req   = 1'b1;
         ulps_req = 1'b1;
      end
      run_len(4'b0100, n); chk(noisy ? "R10 get bridge" : "R5 get bridge", n, 5 * u);
      ta_req   = 1'b0;
      ulps_req = 1'b0;
      run_len(4'b0110, n); chk("R6 mark1", n, u);
      chk("R6 owner stop", int'(obs), 4'b1111);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      int miss;
      repeat (3) @(negedge clk);
      chk("R1 reset key", int'(obs), 4'b1111);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 idle owner", int'(obs), 4'b1111);

      for (int i = 0; i < NVEC; i++) begin
         lpx_cycles  = LPX_W'(VEC[i][0]);
         sure_cycles = (LPX_W+1)'(VEC[i][1]);
         @(negedge clk);
         release_part(VEC[i][2], 1'b0);
         take_part(VEC[i][2], VEC[i][3], 1'b0);
         repeat (2) @(negedge clk);
      end

      // R10: requests and a false Mark-1 during both sequences
      lpx_cycles  = 8'd5;
      sure_cycles = 9'd7;
      @(negedge clk);
      release_part(5, 1'b1);
      take_part(5, 7, 1'b1);
      repeat (2) @(negedge clk);

      // R11: requests while listening are ignored
      release_part(5, 1'b0);
      ta_req   = 1'b1;
      ulps_req = 1'b1;
      miss = 0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (obs != 4'b0011) miss++;
      end
      ta_req   = 1'b0;
      ulps_req = 1'b0;
      chk("R11 listen ignores requests", miss, 0);
      @(negedge clk);
      take_part(5, 7, 1'b0);
      repeat (2) @(negedge clk);

      // R8 / R9: ultra-low-power priority and wake-up length
      wake_cycles = 20'd50;
      ta_req   = 1'b1;
      ulps_req = 1'b1;
      @(negedge clk);
      ta_req = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8 bridge held", int'(obs), 4'b1100);
      ulps_req = 1'b0;
      @(negedge clk);
      run_len(4'b1110, n); chk("R9 wake long", n, 50);
      chk("R9 stop after wake", int'(obs), 4'b1111);
      wake_cycles = 20'd5;
      ulps_req = 1'b1;
      repeat (3) @(negedge clk);
      ulps_req = 1'b0;
      @(negedge clk);
      run_len(4'b1110, n); chk("R9 wake minimum", n, MIN_WAKE);
      repeat (3) @(negedge clk);
      chk("R1 idle after wake", int'(obs), 4'b1111);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule